// File: doc/BRIEF.md
# Shared Cache Maintenance Command Frontend

This block sits between several bus masters and an outer-cache maintenance engine. Each master has its own register port into one common command window. A master that wants a maintenance operation writes a command word. It then writes the address, size, address-mask and way-select registers it needs. Finally it reads its setup-error register. There is no software lock. The hardware grants the command set to one master at a time, and a master that lost finds a nonzero error code and repeats the whole sequence.

When the owning master reads its error register and finds it clean, the accepted command goes to the engine over a valid/ready port. After `eng_valid` rises, the command fields stay frozen until `eng_ready` is seen high at a clock edge. Ownership ends at that handshake. While the engine runs, the queue status shows it busy. A `eng_done` pulse ends the run and sets a completion flag if the command asked for notification. The block also has a primitive register that starts a buffer drain (sync) or a prefetch-buffer flush through a request/acknowledge pair. Any access to that register stalls (ready low) until the drain has been acknowledged.

Top module: `cmq_frontend`

## Requirements
- R1: After reset, the status register (0x260) and every error register (0x25C) read 0, and `eng_valid` and `drain_req` are low.
- R2: A mode write (0x248) while the queue is idle makes that master the owner. When several masters write the mode register in the same cycle, the lowest-indexed one wins. Every losing mode writer reads bit 1 (FE) of 0x25C set.
- R3: A write to 0x24C–0x258 from a master that does not currently own an unlaunched command is ignored. It sets bit 0 (OE) of that master's 0x25C, and only that master's next mode write clears the bit.
- R4: A mode write is rejected with FE set when the queue is owned by another master, or when a launched command is waiting for the handshake or running.
- R5: A mode write by the owner before launch releases its ownership, and the same cycle re-arbitrates among all mode writers. The winner's value replaces the stored command.
- R6: An owner's read of 0x25C launches its command, and `eng_valid` is high in the next cycle. Mode, address, size and ways stay stable while `eng_valid` is high and `eng_ready` is low.
- R7: The scope is mode bits 18:17 (0 range, 1 whole cache, 2 ways) and the target is bits 22:21 (2 explicit ways). Address and size reach the engine only for range scope, and ways only for way scope or way target. All other cases drive zero.
- R8: Status bit 0 is set while the queue is owned or awaiting handshake. Bit 1 is set from the handshake until `eng_done`. Bit 2 (completion) is set by `eng_done` when mode bit 15 was set, so the register then reads exactly 4.
- R9: `eng_done` for a command with mode bit 15 clear leaves the completion flag at 0.
- R10: Writing a value with bit 2 set to 0x260 clears the completion flag.
- R11: Writing 8 to 0x244 raises `drain_req` with `drain_kind` 0, and writing 9 raises it with `drain_kind` 1. It stays high until `drain_ack`. Accesses to 0x244 see `m_ready` low while it is high.
- R12: The registers at 0x248, 0x24C, 0x250, 0x254 and 0x258 read back the last values accepted for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_valid | input | NM | Per-master access request |
| m_write | input | NM | Per-master write (1) or read (0) |
| m_addr | input | NM x AW | Per-master window offset |
| m_wdata | input | NM x DW | Per-master write data |
| m_ready | output | NM | Access completes this cycle |
| m_rdata | output | NM x DW | Read data, valid with m_ready |
| eng_valid | output | 1 | Command offered to the engine |
| eng_ready | input | 1 | Engine takes the command |
| eng_mode | output | DW | Command word |
| eng_addr | output | DW | Range start, zero unless range scope |
| eng_size | output | DW | Range size, zero unless range scope |
| eng_ways | output | DW | Way select, zero unless way scope or target |
| eng_done | input | 1 | Engine finished the running command |
| drain_req | output | 1 | Buffer drain in progress |
| drain_kind | output | 1 | 0 sync drain, 1 prefetch-buffer flush |
| drain_ack | input | 1 | Drain finished |

## Verification
The bench has two masters write the mode register in the same cycle, once from idle and once while one of them already owns the queue. A wrong priority or a missing release hands the command to the wrong master, and the loser then reads a clean error code. A non-owner write is followed by a read-back of the register it targeted. A frontend that lets such writes through shows the intruder's address. The bench holds `eng_ready` low for several cycles after launch and aims a competing mode write into that window, which catches commands that change or get replaced in flight. A table of scope/target mixes checks that only the relevant fields reach the engine. Primitive-register reads during a drain must stall until the acknowledge, and a design that answers at once fails there.

// File: rtl/cmq_pkg.sv
package cmq_pkg;
  localparam int OFF_PRIM = 'h244;
  localparam int OFF_MODE = 'h248;
  localparam int OFF_ADDR = 'h24C;
  localparam int OFF_SIZE = 'h250;
  localparam int OFF_MASK = 'h254;
  localparam int OFF_WAYS = 'h258;
  localparam int OFF_ERR  = 'h25C;
  localparam int OFF_STAT = 'h260;

  localparam int CE_BIT   = 15;
  localparam int SCOPE_LO = 17;
  localparam int TGT_LO   = 21;
  localparam logic [1:0] SCOPE_RANGE = 2'd0;
  localparam logic [1:0] SCOPE_WAYS  = 2'd2;
  localparam logic [1:0] TGT_WAYS    = 2'd2;

  localparam int ST_EF = 2;
  localparam int PRIM_SYNC = 8;
  localparam int PRIM_PFB  = 9;

  typedef enum logic [1:0] {Q_IDLE, Q_OWNED, Q_LAUNCH, Q_RUN} qstate_e;
endpackage

// File: rtl/cmq_arbiter.sv
module cmq_arbiter #(
  parameter int NM = 3,
  localparam int CW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic          open,
  input  logic [NM-1:0] req,
  output logic [NM-1:0] grant,
  output logic [CW-1:0] win_idx,
  output logic          any
);
  always_comb begin
    grant   = '0;
    win_idx = '0;
    any     = 1'b0;
    for (int i = NM - 1; i >= 0; i--) begin
      if (open && req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        win_idx  = CW'(i);
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmq_mflags.sv
module cmq_mflags (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_wr,
  input  logic granted,
  input  logic data_wr,
  input  logic data_ok,
  output logic oe,
  output logic fe
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe <= 1'b0;
      fe <= 1'b0;
    end else if (mode_wr) begin
      oe <= 1'b0;
      fe <= !granted;
    end else if (data_wr && !data_ok) begin
      oe <= 1'b1;
    end
  end
endmodule

// File: rtl/cmq_drain.sv
module cmq_drain
  import cmq_pkg::*;
#(
  parameter int NM = 3,
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NM-1:0]          m_valid,
  input  logic [NM-1:0]          m_write,
  input  logic [NM-1:0][AW-1:0]  m_addr,
  input  logic [NM-1:0][DW-1:0]  m_wdata,
  input  logic                   drain_ack,
  output logic [NM-1:0]          prim_hit,
  output logic [NM-1:0]          prim_ready,
  output logic [DW-1:0]          prim_q,
  output logic                   drain_req,
  output logic                   drain_kind
);
  logic          taken;
  logic          wr_go;
  logic [DW-1:0] wr_val;

  always_comb begin
    taken  = 1'b0;
    wr_go  = 1'b0;
    wr_val = '0;
    for (int i = 0; i < NM; i++) begin
      prim_hit[i]   = m_valid[i] && (m_addr[i] == AW'(OFF_PRIM));
      prim_ready[i] = prim_hit[i] && !taken && !drain_req;
      if (prim_ready[i] && m_write[i]) begin
        wr_go  = 1'b1;
        wr_val = m_wdata[i];
      end
      if (prim_hit[i]) taken = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prim_q     <= '0;
      drain_req  <= 1'b0;
      drain_kind <= 1'b0;
    end else if (wr_go) begin
      prim_q <= wr_val;
      if (wr_val == DW'(PRIM_SYNC) || wr_val == DW'(PRIM_PFB)) begin
        drain_req  <= 1'b1;
        drain_kind <= (wr_val == DW'(PRIM_PFB));
      end
    end else if (drain_ack) begin
      drain_req <= 1'b0;
    end
  end
endmodule

// File: rtl/cmq_frontend.sv
module cmq_frontend
  import cmq_pkg::*;
#(
  parameter int NM = 3,
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NM-1:0]          m_valid,
  input  logic [NM-1:0]          m_write,
  input  logic [NM-1:0][AW-1:0]  m_addr,
  input  logic [NM-1:0][DW-1:0]  m_wdata,
  output logic [NM-1:0]          m_ready,
  output logic [NM-1:0][DW-1:0]  m_rdata,
  output logic                   eng_valid,
  input  logic                   eng_ready,
  output logic [DW-1:0]          eng_mode,
  output logic [DW-1:0]          eng_addr,
  output logic [DW-1:0]          eng_size,
  output logic [DW-1:0]          eng_ways,
  input  logic                   eng_done,
  output logic                   drain_req,
  output logic                   drain_kind,
  input  logic                   drain_ack
);
  localparam int CW = (NM > 1) ? $clog2(NM) : 1;

  qstate_e       q_q;
  logic [CW-1:0] own_q;
  logic [DW-1:0] mode_q, addr_q, size_q, mask_q, ways_q;
  logic          ce_q, ef_q;

  logic [NM-1:0] wr_mode, wr_data, rd_err, data_ok, oe, fe;
  logic [NM-1:0] grant, prim_hit, prim_ready;
  logic [CW-1:0] win_idx;
  logic          any_grant, open, launch, clr_ef, own_wr;
  logic [DW-1:0] prim_q;
  logic [1:0]    scope, tgt;

  always_comb begin
    for (int i = 0; i < NM; i++) begin
      wr_mode[i] = m_valid[i] && m_write[i] && (m_addr[i] == AW'(OFF_MODE));
      wr_data[i] = m_valid[i] && m_write[i] &&
                   (m_addr[i] == AW'(OFF_ADDR) || m_addr[i] == AW'(OFF_SIZE) ||
                    m_addr[i] == AW'(OFF_MASK) || m_addr[i] == AW'(OFF_WAYS));
      rd_err[i]  = m_valid[i] && !m_write[i] && (m_addr[i] == AW'(OFF_ERR));
      data_ok[i] = (q_q == Q_OWNED) && (own_q == CW'(i));
    end
  end

  always_comb begin
    clr_ef = 1'b0;
    for (int i = 0; i < NM; i++)
      if (m_valid[i] && m_write[i] && m_addr[i] == AW'(OFF_STAT) && m_wdata[i][ST_EF])
        clr_ef = 1'b1;
  end

  assign open   = (q_q == Q_IDLE) || ((q_q == Q_OWNED) && wr_mode[own_q]);
  assign own_wr = (q_q == Q_OWNED) && wr_data[own_q];
  assign launch = (q_q == Q_OWNED) && !any_grant && rd_err[own_q];

  cmq_arbiter #(.NM(NM)) u_arb (
    .open    (open),
    .req     (wr_mode),
    .grant   (grant),
    .win_idx (win_idx),
    .any     (any_grant)
  );

  cmq_drain #(.NM(NM), .AW(AW), .DW(DW)) u_drain (
    .clk        (clk),
    .rst_n      (rst_n),
    .m_valid    (m_valid),
    .m_write    (m_write),
    .m_addr     (m_addr),
    .m_wdata    (m_wdata),
    .drain_ack  (drain_ack),
    .prim_hit   (prim_hit),
    .prim_ready (prim_ready),
    .prim_q     (prim_q),
    .drain_req  (drain_req),
    .drain_kind (drain_kind)
  );

  for (genvar g = 0; g < NM; g++) begin : g_master
    cmq_mflags u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode_wr (wr_mode[g]),
      .granted (grant[g]),
      .data_wr (wr_data[g]),
      .data_ok (data_ok[g]),
      .oe      (oe[g]),
      .fe      (fe[g])
    );

    always_comb begin
      m_ready[g] = prim_hit[g] ? prim_ready[g] : 1'b1;
      m_rdata[g] = '0;
      if (m_addr[g] == AW'(OFF_PRIM))      m_rdata[g] = prim_q;
      else if (m_addr[g] == AW'(OFF_MODE)) m_rdata[g] = mode_q;
      else if (m_addr[g] == AW'(OFF_ADDR)) m_rdata[g] = addr_q;
      else if (m_addr[g] == AW'(OFF_SIZE)) m_rdata[g] = size_q;
      else if (m_addr[g] == AW'(OFF_MASK)) m_rdata[g] = mask_q;
      else if (m_addr[g] == AW'(OFF_WAYS)) m_rdata[g] = ways_q;
      else if (m_addr[g] == AW'(OFF_ERR))  m_rdata[g] = DW'({fe[g], oe[g]});
      else if (m_addr[g] == AW'(OFF_STAT))
        m_rdata[g] = DW'({ef_q, q_q == Q_RUN, (q_q == Q_OWNED) || (q_q == Q_LAUNCH)});
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_q    <= Q_IDLE;
      own_q  <= '0;
      mode_q <= '0;
      addr_q <= '0;
      size_q <= '0;
      mask_q <= '0;
      ways_q <= '0;
      ce_q   <= 1'b0;
    end else begin
      if (any_grant) begin
        q_q    <= Q_OWNED;
        own_q  <= win_idx;
        mode_q <= m_wdata[win_idx];
      end
      if (own_wr) begin
        if (m_addr[own_q] == AW'(OFF_ADDR))      addr_q <= m_wdata[own_q];
        else if (m_addr[own_q] == AW'(OFF_SIZE)) size_q <= m_wdata[own_q];
        else if (m_addr[own_q] == AW'(OFF_MASK)) mask_q <= m_wdata[own_q];
        else                                     ways_q <= m_wdata[own_q];
      end
      case (q_q)
        Q_OWNED:  if (launch) q_q <= Q_LAUNCH;
        Q_LAUNCH: if (eng_ready) begin
                    q_q  <= Q_RUN;
                    ce_q <= mode_q[CE_BIT];
                  end
        Q_RUN:    if (eng_done) q_q <= Q_IDLE;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                 ef_q <= 1'b0;
    else if ((q_q == Q_RUN) && eng_done && ce_q) ef_q <= 1'b1;
    else if (clr_ef)                            ef_q <= 1'b0;
  end

  assign scope     = mode_q[SCOPE_LO +: 2];
  assign tgt       = mode_q[TGT_LO +: 2];
  assign eng_valid = (q_q == Q_LAUNCH);
  assign eng_mode  = mode_q;
  assign eng_addr  = (scope == SCOPE_RANGE) ? addr_q : '0;
  assign eng_size  = (scope == SCOPE_RANGE) ? size_q : '0;
  assign eng_ways  = (scope == SCOPE_WAYS || tgt == TGT_WAYS) ? ways_q : '0;
endmodule

// File: rtl/cmq_frontend_chk.sv
module cmq_frontend_chk
  import cmq_pkg::*;
#(
  parameter int NM = 3,
  parameter int AW = 12,
  parameter int DW = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NM-1:0]         m_valid,
  input logic [NM-1:0][AW-1:0] m_addr,
  input logic [NM-1:0]         m_ready,
  input logic                  eng_valid,
  input logic                  eng_ready,
  input logic [DW-1:0]         eng_mode,
  input logic [DW-1:0]         eng_addr,
  input logic [DW-1:0]         eng_size,
  input logic [DW-1:0]         eng_ways,
  input logic                  eng_done,
  input logic                  drain_req,
  input logic                  drain_ack,
  input logic [NM-1:0]         grant,
  input logic                  ef_q
);
  p_offer_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid && !eng_ready |=> eng_valid && $stable(eng_mode) && $stable(eng_addr)
                                && $stable(eng_size) && $stable(eng_ways));

  p_single_winner_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_flag_from_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ef_q) |-> $past(eng_done));

  p_drain_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    drain_req && !drain_ack |=> drain_req);

  for (genvar g = 0; g < NM; g++) begin : g_stall
    p_prim_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
      drain_req && m_valid[g] && (m_addr[g] == AW'(OFF_PRIM)) |-> !m_ready[g]);
  end
endmodule

bind cmq_frontend cmq_frontend_chk #(.NM(NM), .AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .m_valid   (m_valid),
  .m_addr    (m_addr),
  .m_ready   (m_ready),
  .eng_valid (eng_valid),
  .eng_ready (eng_ready),
  .eng_mode  (eng_mode),
  .eng_addr  (eng_addr),
  .eng_size  (eng_size),
  .eng_ways  (eng_ways),
  .eng_done  (eng_done),
  .drain_req (drain_req),
  .drain_ack (drain_ack),
  .grant     (grant),
  .ef_q      (ef_q)
);

// File: tb/cmq_frontend_bench.sv
module cmq_frontend_bench;
  localparam int NM = 3;
  localparam int AW = 12;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NM-1:0] m_valid = '0;
  logic [NM-1:0] m_write = '0;
  logic [NM-1:0][AW-1:0] m_addr = '0;
  logic [NM-1:0][DW-1:0] m_wdata = '0;
  logic [NM-1:0] m_ready;
  logic [NM-1:0][DW-1:0] m_rdata;
  logic eng_valid, drain_req, drain_kind;
  logic eng_ready = 1'b0, eng_done = 1'b0, drain_ack = 1'b0;
  logic [DW-1:0] eng_mode, eng_addr, eng_size, eng_ways;
  logic [DW-1:0] rv;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  cmq_frontend #(.NM(NM), .AW(AW), .DW(DW)) u_cmq_frontend (
    .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_write(m_write),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_ready(m_ready), .m_rdata(m_rdata),
    .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_mode(eng_mode),
    .eng_addr(eng_addr), .eng_size(eng_size), .eng_ways(eng_ways),
    .eng_done(eng_done), .drain_req(drain_req), .drain_kind(drain_kind),
    .drain_ack(drain_ack));

  // {mode, addr, size, ways, exp_addr, exp_size, exp_ways, exp_status}
  localparam logic [7:0][31:0] VEC [5] = '{
    {32'h0000_8002, 32'h1000, 32'h80,  32'hF,  32'h1000, 32'h80,  32'h0,  32'h4},
    {32'h0002_8000, 32'h1000, 32'h80,  32'hF,  32'h0,    32'h0,   32'h0,  32'h4},
    {32'h0004_0001, 32'h3000, 32'h40,  32'hF0, 32'h0,    32'h0,   32'hF0, 32'h0},
    {32'h0040_8005, 32'h2000, 32'h100, 32'h3,  32'h2000, 32'h100, 32'h3,  32'h4},
    {32'h0020_0003, 32'h4000, 32'h80,  32'h7,  32'h4000, 32'h80,  32'h0,  32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input int i, input bit wr, input int a, input logic [31:0] d,
                     output logic [31:0] rd);
    @(negedge clk);
    m_valid[i] = 1'b1; m_write[i] = wr; m_addr[i] = AW'(a); m_wdata[i] = d;
    #1;
    while (!m_ready[i]) begin @(negedge clk); #1; end
    rd = m_rdata[i];
    @(posedge clk); #1;
    m_valid[i] = 1'b0;
  endtask

  task automatic wr(input int i, input int a, input logic [31:0] d);
    logic [31:0] unused;
    acc(i, 1'b1, a, d, unused);
  endtask

  task automatic dual_mode(input int i, input logic [31:0] di, input int j, input logic [31:0] dj);
    @(negedge clk);
    m_valid[i] = 1'b1; m_write[i] = 1'b1; m_addr[i] = AW'('h248); m_wdata[i] = di;
    m_valid[j] = 1'b1; m_write[j] = 1'b1; m_addr[j] = AW'('h248); m_wdata[j] = dj;
    @(posedge clk); #1;
    m_valid[i] = 1'b0; m_valid[j] = 1'b0;
  endtask

  task automatic accept();
    @(negedge clk); eng_ready = 1'b1;
    @(posedge clk); #1; eng_ready = 1'b0;
  endtask

  task automatic finish_cmd();
    @(negedge clk); eng_done = 1'b1;
    @(posedge clk); #1; eng_done = 1'b0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    acc(0, 1'b0, 'h260, 0, rv); chk("R1 status", rv, 0);
    acc(1, 1'b0, 'h25C, 0, rv); chk("R1 err", rv, 0);
    chk("R1 eng_valid", 32'(eng_valid), 0);
    chk("R1 drain_req", 32'(drain_req), 0);

    // R7/R8/R9/R10 table of scope/target mixes
    for (int k = 0; k < 5; k++) begin
      wr(0, 'h248, VEC[k][7]);
      wr(0, 'h24C, VEC[k][6]);
      wr(0, 'h250, VEC[k][5]);
      wr(0, 'h258, VEC[k][4]);
      acc(0, 1'b0, 'h25C, 0, rv); chk("R6 owner err clean", rv, 0);
      @(negedge clk);
      chk("R6 launch valid", 32'(eng_valid), 1);
      chk("R7 mode", eng_mode, VEC[k][7]);
      chk("R7 addr", eng_addr, VEC[k][3]);
      chk("R7 size", eng_size, VEC[k][2]);
      chk("R7 ways", eng_ways, VEC[k][1]);
      accept();
      finish_cmd();
      acc(2, 1'b0, 'h260, 0, rv); chk("R8 R9 status after done", rv, VEC[k][0]);
      wr(1, 'h260, 32'h4);
      acc(2, 1'b0, 'h260, 0, rv); chk("R10 flag cleared", rv, 0);
    end

    // R2 simultaneous mode writes from idle
    dual_mode(1, 32'h0000_8002, 2, 32'h1);
    acc(2, 1'b0, 'h25C, 0, rv); chk("R2 loser FE", rv, 2);
    // R3 intruder write ignored
    wr(1, 'h24C, 32'h100);
    wr(0, 'h24C, 32'h200);
    acc(0, 1'b0, 'h25C, 0, rv); chk("R3 intruder OE", rv, 1);
    acc(0, 1'b0, 'h24C, 0, rv); chk("R3 addr unchanged", rv, 32'h100);
    wr(1, 'h250, 32'h80);
    wr(1, 'h254, 32'hFFF0);
    wr(1, 'h258, 32'h5);
    acc(2, 1'b0, 'h254, 0, rv); chk("R12 mask readback", rv, 32'hFFF0);
    acc(2, 1'b0, 'h258, 0, rv); chk("R12 ways readback", rv, 32'h5);
    // R4 mode write while owned by another
    wr(0, 'h248, 32'h7);
    acc(0, 1'b0, 'h25C, 0, rv); chk("R4 rejected FE, OE cleared", rv, 2);
    acc(0, 1'b0, 'h260, 0, rv); chk("R8 queue busy", rv, 1);
    // R5 owner rewrites its mode
    wr(1, 'h248, 32'h0000_8001);
    acc(0, 1'b0, 'h248, 0, rv); chk("R5 mode replaced", rv, 32'h0000_8001);
    acc(1, 1'b0, 'h25C, 0, rv); chk("R5 owner kept", rv, 0);
    @(negedge clk);
    chk("R6 valid after launch", 32'(eng_valid), 1);
    chk("R6 mode", eng_mode, 32'h0000_8001);
    chk("R7 range addr", eng_addr, 32'h100);
    wr(2, 'h248, 32'h2);
    acc(2, 1'b0, 'h25C, 0, rv); chk("R4 rejected while launched", rv, 2);
    @(negedge clk);
    chk("R6 still offered", 32'(eng_valid), 1);
    chk("R6 mode stable", eng_mode, 32'h0000_8001);
    acc(0, 1'b0, 'h260, 0, rv); chk("R8 awaiting handshake", rv, 1);
    accept();
    chk("R6 released", 32'(eng_valid), 0);
    acc(0, 1'b0, 'h260, 0, rv); chk("R8 engine busy", rv, 2);
    wr(0, 'h248, 32'h3);
    acc(0, 1'b0, 'h25C, 0, rv); chk("R4 rejected while running", rv, 2);
    finish_cmd();
    acc(0, 1'b0, 'h260, 0, rv); chk("R8 exactly flag", rv, 4);
    wr(2, 'h260, 32'h4);

    // R5 re-arbitration when owner rewrites alongside another master
    wr(2, 'h248, 32'h2);
    dual_mode(0, 32'h1, 2, 32'h3);
    acc(2, 1'b0, 'h25C, 0, rv); chk("R5 preempted owner FE", rv, 2);
    acc(1, 1'b0, 'h248, 0, rv); chk("R5 winner mode", rv, 32'h1);
    acc(0, 1'b0, 'h25C, 0, rv); chk("R5 new owner clean", rv, 0);
    @(negedge clk);
    chk("R5 launched by new owner", eng_mode, 32'h1);
    accept();
    finish_cmd();
    acc(1, 1'b0, 'h260, 0, rv); chk("R9 no flag without bit15", rv, 0);

    // R11 sync drain and prefetch-buffer flush
    wr(1, 'h244, 32'h8);
    @(negedge clk);
    chk("R11 sync req", 32'(drain_req), 1);
    chk("R11 sync kind", 32'(drain_kind), 0);
    m_valid[1] = 1'b1; m_write[1] = 1'b0; m_addr[1] = AW'('h244);
    #1; chk("R11 read stalls", 32'(m_ready[1]), 0);
    @(negedge clk); #1; chk("R11 still stalled", 32'(m_ready[1]), 0);
    drain_ack = 1'b1;
    @(posedge clk); #1; drain_ack = 1'b0;
    @(negedge clk); #1;
    chk("R11 ready after ack", 32'(m_ready[1]), 1);
    chk("R11 primitive readback", m_rdata[1], 32'h8);
    chk("R11 req dropped", 32'(drain_req), 0);
    @(posedge clk); #1; m_valid[1] = 1'b0;
    wr(0, 'h244, 32'h9);
    @(negedge clk);
    chk("R11 pfb req", 32'(drain_req), 1);
    chk("R11 pfb kind", 32'(drain_kind), 1);
    drain_ack = 1'b1;
    @(posedge clk); #1; drain_ack = 1'b0;
    @(negedge clk);
    chk("R11 pfb done", 32'(drain_req), 0);

    summary();
  end
endmodule